// File: doc/BRIEF.md
# Flash Bus Front-End Controller

This block sits between the external pins of a parallel NOR-style flash device and its internal command logic. It takes the active-low chip-enable, output-enable and write-enable pins through two-flop synchronizers. It accepts a bus write only when the three pins are in the write combination for long enough, and the device has been armed since power-up. An accepted write is presented as a one-cycle command strobe, with the captured address, command byte and write data.

It also runs the hardware reset pin. A low pulse narrower than a minimum width is treated as noise. A wide enough pulse asks the internal state machine to return to read mode a fixed time after the falling edge. Reads are then held off for a recovery window after the pin rises. While the reset pin is low, the device is in standby, its data outputs are released and its ready/busy output is marked as meaningless. A supply-lockout input, standing in for the supply detector, forces read mode and blocks writes. The byte/word select reshapes the data lanes and the lowest address bit for both reads and writes.

Each output is plain and level-based. The command strobe has no ready signal and no back-pressure: the command decoder must take `cmd_valid` in the cycle it is high, because the pins cannot be stalled. Successive strobes are always at least several cycles apart.

Top module: `flash_bus_frontend`

## Requirements
- R1: A bus write is accepted when synchronized chip-enable and write-enable are both low while output-enable is high, and the first of chip-enable or write-enable then rises with output-enable still high. Acceptance gives exactly one cycle of `cmd_valid`.
- R2: If output-enable falls while chip-enable and write-enable are low, the cycle is abandoned and no strobe follows. Output-enable low never lets a write start.
- R3: A write-active interval shorter than `GLITCH_CYC` clock cycles produces no strobe. This holds whether the short pulse is on write-enable or on chip-enable.
- R4: After `rst_n` is released, no write is accepted until the write combination has been seen absent at least once. If the pins come out of reset with chip-enable and write-enable low, the first rising edge yields no strobe.
- R5: While `supply_lock` is high, `read_mode_req` is high from the next cycle on and no strobe is issued. `read_mode_req` is also high during `rst_n` reset.
- R6: A low pulse on `hw_rst_n` shorter than `RST_MIN_NS` causes no read-mode request. It also leaves `read_allow` high within a few cycles of the pin rising.
- R7: A low pulse on `hw_rst_n` of at least `RST_MIN_NS` raises `read_mode_req` for one cycle, `RST_ABORT_NS` after the falling edge, to within the synchronizer delay. The pin may have been released before that time.
- R8: While `hw_rst_n` is low, `standby` and `busy_ignore` are high, `dq_oe` is all zero, `read_allow` is low and no strobe is issued.
- R9: After a qualifying reset pulse, `read_allow` stays low for `REC_NS` after the pin rises, then returns high.
- R10: Word mode is `wide_sel` = 1: reads enable all 16 `dq_oe` bits, `dq_out` equals `arr_rdata` and `rd_addr` = {addr, 0}. Byte mode is `wide_sel` = 0: `dq_in[15]` is the lowest address bit, so `rd_addr` = {addr, dq_in[15]}. Only `dq_oe[7:0]` are set, and `dq_out` = {8'h00, `dq_in[15]` ? `arr_rdata[15:8]` : `arr_rdata[7:0]`}.
- R11: `cmd_code` is always the low data byte of the write. `cmd_wdata` is the full 16-bit bus in word mode and {8'h00, low byte} in byte mode. `cmd_addr` follows the R10 address mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| ce_n | input | 1 | Chip-enable pin, active low |
| oe_n | input | 1 | Output-enable pin, active low |
| we_n | input | 1 | Write-enable pin, active low |
| hw_rst_n | input | 1 | Hardware reset pin, active low |
| wide_sel | input | 1 | 1 = 16-bit word bus, 0 = 8-bit byte bus |
| supply_lock | input | 1 | Supply lockout from the external detector |
| addr_pin | input | AW | Word address pins |
| dq_in | input | 16 | Data pins as driven by the host |
| arr_rdata | input | 16 | Read data from the array |
| cmd_valid | output | 1 | One-cycle strobe of an accepted write |
| cmd_addr | output | AW+1 | Byte-granular address of the accepted write |
| cmd_code | output | 8 | Low data byte of the accepted write |
| cmd_wdata | output | 16 | Write data, lane-mapped for the bus width |
| rd_addr | output | AW+1 | Byte-granular read address to the array |
| dq_out | output | 16 | Read data toward the pins |
| dq_oe | output | 16 | Per-pin output enable of the data pins |
| read_mode_req | output | 1 | Request to the state machine to enter read mode |
| standby | output | 1 | Device held in standby by the reset pin |
| busy_ignore | output | 1 | Ready/busy output is not meaningful |
| read_allow | output | 1 | Reads permitted (no reset, recovery over) |

## Verification
The bench targets the cases that fall through a naive design. A part powered up with its write pins already low would take a phantom command if the arming rule were missing. Output-enable dropping mid-cycle would still be strobed if only the rising edge were watched. One-cycle pulses on either enable would be accepted without the glitch filter. A reset pulse just under the minimum width would wrongly trigger the read-mode request, or leave reads blocked for a recovery window. The bench also runs a valid pulse whose pin is released long before the abort time, to catch a timer that stops when the pin rises. Byte mode is checked on both values of the top data pin, where a swapped lane select or a missing upper-byte mask shows up in `dq_out`, `rd_addr` and `cmd_wdata`.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;

  localparam int DQ_W   = 16;
  localparam int CODE_W = 8;

  // synchronized control pins, all active as named
  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic hrst_n;
    logic wide;
  } ctl_pins_t;

  // round a duration in ns up to whole clock cycles
  function automatic int ns_to_cyc(input int ns, input int mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

endpackage

// File: rtl/fe_sync.sv
module fe_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st[0] <= INIT;
    else        st[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[i] <= INIT;
      else        st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/fe_write_qual.sv
module fe_write_qual
  import flash_fe_pkg::*;
#(
  parameter int AW         = 18,
  parameter int GLITCH_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_ok,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              wide,
  input  logic              block,
  input  logic [AW-1:0]     addr,
  input  logic [DQ_W-1:0]   dq,
  output logic              cmd_valid,
  output logic [AW:0]       cmd_addr,
  output logic [CODE_W-1:0] cmd_code,
  output logic [DQ_W-1:0]   cmd_wdata
);
  localparam int CW = $clog2(GLITCH_CYC + 1);

  logic              act, act_q, armed, spoil, exit_now, fire;
  logic [CW-1:0]     cnt;
  logic [AW:0]       cap_addr;
  logic [CODE_W-1:0] cap_code;
  logic [DQ_W-1:0]   cap_wdata;

  assign act      = !ce_n && !we_n && oe_n;
  assign exit_now = act_q && !act;
  // rising write-enable or chip-enable closes the cycle; output-enable must still be high
  assign fire     = exit_now && oe_n && (cnt == CW'(GLITCH_CYC)) && !spoil && !block;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q     <= 1'b0;
      armed     <= 1'b0;
      spoil     <= 1'b0;
      cnt       <= '0;
      cap_addr  <= '0;
      cap_code  <= '0;
      cap_wdata <= '0;
      cmd_valid <= 1'b0;
      cmd_addr  <= '0;
      cmd_code  <= '0;
      cmd_wdata <= '0;
    end else begin
      act_q <= act;
      if (sync_ok && !act) armed <= 1'b1;

      if (act) begin
        if (cnt != CW'(GLITCH_CYC)) cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
      end

      if (act && (block || !armed)) spoil <= 1'b1;
      else if (!act)                spoil <= 1'b0;

      if (act) begin
        cap_addr  <= wide ? {addr, 1'b0} : {addr, dq[DQ_W-1]};
        cap_code  <= dq[CODE_W-1:0];
        cap_wdata <= wide ? dq : {{(DQ_W-CODE_W){1'b0}}, dq[CODE_W-1:0]};
      end

      cmd_valid <= fire;
      if (fire) begin
        cmd_addr  <= cap_addr;
        cmd_code  <= cap_code;
        cmd_wdata <= cap_wdata;
      end
    end
  end
endmodule

// File: rtl/fe_reset_seq.sv
module fe_reset_seq #(
  parameter int MIN_CYC   = 125,
  parameter int ABORT_CYC = 5000,
  parameter int REC_CYC   = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic standby,
  output logic abort_pulse,
  output logic read_allow
);
  localparam int LW = $clog2(MIN_CYC + 1);
  localparam int TW = $clog2(ABORT_CYC + 1);
  localparam int RW = $clog2(REC_CYC + 1);

  logic          prev, pending;
  logic [LW-1:0] low_cnt;
  logic [TW-1:0] tmr;
  logic [RW-1:0] rec;
  logic          fall, qualify, abort_now;

  assign fall      = prev && !pin_n;
  assign qualify   = !pin_n && (low_cnt == LW'(MIN_CYC - 1));
  assign abort_now = pending && (tmr == TW'(ABORT_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev        <= 1'b1;
      pending     <= 1'b0;
      low_cnt     <= '0;
      tmr         <= TW'(ABORT_CYC);
      rec         <= '0;
      abort_pulse <= 1'b0;
    end else begin
      prev <= pin_n;

      if (!pin_n) begin
        if (low_cnt != LW'(MIN_CYC)) low_cnt <= low_cnt + 1'b1;
      end else begin
        low_cnt <= '0;
      end

      // timer counts from the falling edge and keeps running after release
      if (fall && !pending)          tmr <= TW'(1);
      else if (tmr != TW'(ABORT_CYC)) tmr <= tmr + 1'b1;

      if (abort_now)    pending <= 1'b0;
      else if (qualify) pending <= 1'b1;

      abort_pulse <= abort_now;

      // recovery held full while a qualified pulse is low, drains after release
      if (!pin_n && (qualify || rec != '0)) rec <= RW'(REC_CYC);
      else if (rec != '0)                   rec <= rec - 1'b1;
    end
  end

  assign standby    = !pin_n;
  assign read_allow = pin_n && (rec == '0);
endmodule

// File: rtl/fe_lane_map.sv
module fe_lane_map
  import flash_fe_pkg::*;
#(
  parameter int AW = 18
) (
  input  logic            wide,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic            dq_top,
  input  logic [DQ_W-1:0] arr_rdata,
  output logic [AW:0]     rd_addr,
  output logic [DQ_W-1:0] dq_out,
  output logic [DQ_W-1:0] dq_oe
);
  localparam int HI_W = DQ_W - CODE_W;

  logic [CODE_W-1:0] byte_sel;

  assign byte_sel = dq_top ? arr_rdata[DQ_W-1:CODE_W] : arr_rdata[CODE_W-1:0];
  assign rd_addr  = wide ? {addr, 1'b0} : {addr, dq_top};

  for (genvar i = 0; i < DQ_W; i++) begin : g_lane
    if (i < CODE_W) begin : g_lo
      assign dq_oe[i]  = rd_en;
      assign dq_out[i] = wide ? arr_rdata[i] : byte_sel[i];
    end else begin : g_hi
      // in byte mode the upper pins are released; the top one carries address
      assign dq_oe[i]  = rd_en && wide;
      assign dq_out[i] = wide && arr_rdata[i];
    end
  end

  if (HI_W <= 0) begin : g_bad_width
    initial $display("fe_lane_map: bus narrower than a byte");
  end
endmodule

// File: rtl/flash_bus_frontend.sv
module flash_bus_frontend
  import flash_fe_pkg::*;
#(
  parameter int AW           = 18,
  parameter int CLK_MHZ      = 250,
  parameter int RST_MIN_NS   = 500,
  parameter int RST_ABORT_NS = 20000,
  parameter int REC_NS       = 80,
  parameter int GLITCH_CYC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              hw_rst_n,
  input  logic              wide_sel,
  input  logic              supply_lock,
  input  logic [AW-1:0]     addr_pin,
  input  logic [DQ_W-1:0]   dq_in,
  input  logic [DQ_W-1:0]   arr_rdata,
  output logic              cmd_valid,
  output logic [AW:0]       cmd_addr,
  output logic [CODE_W-1:0] cmd_code,
  output logic [DQ_W-1:0]   cmd_wdata,
  output logic [AW:0]       rd_addr,
  output logic [DQ_W-1:0]   dq_out,
  output logic [DQ_W-1:0]   dq_oe,
  output logic              read_mode_req,
  output logic              standby,
  output logic              busy_ignore,
  output logic              read_allow
);
  localparam int MIN_CYC   = ns_to_cyc(RST_MIN_NS, CLK_MHZ);
  localparam int ABORT_CYC = ns_to_cyc(RST_ABORT_NS, CLK_MHZ);
  localparam int REC_CYC   = ns_to_cyc(REC_NS, CLK_MHZ);
  localparam int CTL_W     = $bits(ctl_pins_t);
  localparam int BUS_W     = AW + DQ_W;

  ctl_pins_t       ctl_raw, ctl_s;
  logic [BUS_W-1:0] bus_s;
  logic [AW-1:0]    addr_s;
  logic [DQ_W-1:0]  dq_s;
  logic [1:0]       warm;
  logic             block, rd_en, abort_pulse, rmr;

  assign ctl_raw = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n, hrst_n: hw_rst_n, wide: wide_sel};

  fe_sync #(.W(CTL_W), .STAGES(2), .INIT({CTL_W{1'b1}})) u_sync_ctl (
    .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s)
  );

  fe_sync #(.W(BUS_W), .STAGES(2), .INIT('0)) u_sync_bus (
    .clk(clk), .rst_n(rst_n), .d({addr_pin, dq_in}), .q(bus_s)
  );

  assign addr_s = bus_s[BUS_W-1:DQ_W];
  assign dq_s   = bus_s[DQ_W-1:0];

  // synchronizer contents are real pin values only after it has filled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= '0;
    else        warm <= {warm[0], 1'b1};
  end

  assign block = supply_lock || !ctl_s.hrst_n;

  fe_write_qual #(.AW(AW), .GLITCH_CYC(GLITCH_CYC)) u_wq (
    .clk(clk), .rst_n(rst_n), .sync_ok(warm[1]),
    .ce_n(ctl_s.ce_n), .oe_n(ctl_s.oe_n), .we_n(ctl_s.we_n), .wide(ctl_s.wide),
    .block(block), .addr(addr_s), .dq(dq_s),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_code(cmd_code), .cmd_wdata(cmd_wdata)
  );

  fe_reset_seq #(.MIN_CYC(MIN_CYC), .ABORT_CYC(ABORT_CYC), .REC_CYC(REC_CYC)) u_rs (
    .clk(clk), .rst_n(rst_n), .pin_n(ctl_s.hrst_n),
    .standby(standby), .abort_pulse(abort_pulse), .read_allow(read_allow)
  );

  assign rd_en = !ctl_s.ce_n && !ctl_s.oe_n && ctl_s.we_n && read_allow;

  fe_lane_map #(.AW(AW)) u_lane (
    .wide(ctl_s.wide), .rd_en(rd_en), .addr(addr_s), .dq_top(dq_s[DQ_W-1]),
    .arr_rdata(arr_rdata), .rd_addr(rd_addr), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rmr <= 1'b1;
    else        rmr <= supply_lock || abort_pulse;
  end

  assign read_mode_req = rmr;
  assign busy_ignore   = standby;
endmodule

// File: rtl/flash_bus_frontend_chk.sv
module flash_bus_frontend_chk #(
  parameter int AW = 18
) (
  input logic        clk,
  input logic        rst_n,
  input logic        supply_lock,
  input logic        cmd_valid,
  input logic [15:0] dq_oe,
  input logic [15:0] dq_out,
  input logic        read_mode_req,
  input logic        standby,
  input logic        busy_ignore,
  input logic        read_allow
);
  assert_strobe_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  assert_lock_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(supply_lock) |-> !cmd_valid);

  assert_lock_readmode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(supply_lock) |-> read_mode_req);

  assert_standby_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> (dq_oe == 16'h0000) && busy_ignore && !read_allow);

  assert_byte_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe[0] && !dq_oe[15]) |-> (dq_out[15:8] == 8'h00) && (dq_oe[14:8] == 7'h00));

  assert_recovery_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(read_allow) |-> !standby);
endmodule

bind flash_bus_frontend flash_bus_frontend_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_lock(supply_lock), .cmd_valid(cmd_valid),
  .dq_oe(dq_oe), .dq_out(dq_out), .read_mode_req(read_mode_req),
  .standby(standby), .busy_ignore(busy_ignore), .read_allow(read_allow)
);

// File: tb/flash_bus_frontend_tb.sv
module flash_bus_frontend_tb;
  localparam int AW        = 18;
  localparam int MIN_CYC   = 125;   // 500 ns at 250 MHz
  localparam int ABORT_CYC = 5000;  // 20 us at 250 MHz
  localparam int REC_CYC   = 20;    // 80 ns at 250 MHz

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, ce_n, oe_n, we_n, hw_rst_n, wide_sel, supply_lock;
  logic [AW-1:0] addr_pin;
  logic [15:0]   dq_in, arr_rdata;
  logic          cmd_valid, read_mode_req, standby, busy_ignore, read_allow;
  logic [AW:0]   cmd_addr, rd_addr;
  logic [7:0]    cmd_code;
  logic [15:0]   cmd_wdata, dq_out, dq_oe;

  flash_bus_frontend #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .hw_rst_n(hw_rst_n), .wide_sel(wide_sel), .supply_lock(supply_lock),
    .addr_pin(addr_pin), .dq_in(dq_in), .arr_rdata(arr_rdata),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_code(cmd_code), .cmd_wdata(cmd_wdata),
    .rd_addr(rd_addr), .dq_out(dq_out), .dq_oe(dq_oe), .read_mode_req(read_mode_req),
    .standby(standby), .busy_ignore(busy_ignore), .read_allow(read_allow)
  );

  int tests = 0, fails = 0;
  int strobes = 0, rmr_cyc = 0;
  logic [AW:0] last_addr;
  logic [7:0]  last_code;
  logic [15:0] last_wdata;
  logic done = 1'b0;

  always @(negedge clk) begin
    if (rst_n && cmd_valid) begin
      strobes++;
      last_addr  = cmd_addr;
      last_code  = cmd_code;
      last_wdata = cmd_wdata;
    end
    if (rst_n && read_mode_req) rmr_cyc++;
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ctl: 0 write-enable pulse, 1 chip-enable pulse, 2 output-enable drops mid-cycle
  typedef struct packed {
    logic [1:0]  ctl;
    logic [3:0]  width;
    logic        wide;
    logic [17:0] addr;
    logic [15:0] data;
    logic        exp;
    logic [18:0] eaddr;
    logic [7:0]  ecode;
    logic [15:0] ewdata;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 4'd4, 1'b1, 18'h00555, 16'hAAAA, 1'b1, 19'h00AAA, 8'hAA, 16'hAAAA},
    '{2'd0, 4'd2, 1'b1, 18'h02AAA, 16'h1255, 1'b1, 19'h05554, 8'h55, 16'h1255},
    '{2'd0, 4'd1, 1'b1, 18'h00123, 16'h0011, 1'b0, 19'h0,     8'h00, 16'h0000},
    '{2'd0, 4'd3, 1'b0, 18'h00AAA, 16'h80F0, 1'b1, 19'h01555, 8'hF0, 16'h00F0},
    '{2'd1, 4'd3, 1'b0, 18'h00555, 16'h7F90, 1'b1, 19'h00AAA, 8'h90, 16'h0090},
    '{2'd2, 4'd3, 1'b1, 18'h00555, 16'hAAAA, 1'b0, 19'h0,     8'h00, 16'h0000},
    '{2'd1, 4'd6, 1'b1, 18'h3FFFF, 16'hFFFF, 1'b1, 19'h7FFFE, 8'hFF, 16'hFFFF},
    '{2'd1, 4'd1, 1'b0, 18'h00077, 16'h0033, 1'b0, 19'h0,     8'h00, 16'h0000}
  };

  task automatic bus_write(input vec_t v);
    wide_sel = v.wide; addr_pin = v.addr; dq_in = v.data;
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    tick(4);
    case (v.ctl)
      2'd1: begin
        we_n = 1'b0; tick(1);
        ce_n = 1'b0; tick(int'(v.width));
        ce_n = 1'b1; tick(1);
        we_n = 1'b1;
      end
      2'd2: begin
        ce_n = 1'b0; tick(1);
        we_n = 1'b0; tick(3);
        oe_n = 1'b0; tick(1);
        we_n = 1'b1; tick(1);
        oe_n = 1'b1; ce_n = 1'b1;
      end
      default: begin
        ce_n = 1'b0; tick(1);
        we_n = 1'b0; tick(int'(v.width));
        we_n = 1'b1; tick(1);
        ce_n = 1'b1;
      end
    endcase
    tick(6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int s0, r0;
    rst_n = 1'b0; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;   // pins already in write combination
    hw_rst_n = 1'b1; wide_sel = 1'b1; supply_lock = 1'b0;
    addr_pin = '0; dq_in = 16'h00A5; arr_rdata = 16'hBEEF;
    tick(5);
    chk(cmd_valid == 1'b0, "R1 reset strobe", {31'd0, cmd_valid}, 32'd0);
    chk(read_mode_req == 1'b1, "R5 reset read-mode", {31'd0, read_mode_req}, 32'd1);
    chk(dq_oe == 16'h0, "R8 reset dq_oe", {16'd0, dq_oe}, 32'd0);
    rst_n = 1'b1;
    tick(6);
    // R4: first rise of write-enable after power-up with pins low
    s0 = strobes;
    we_n = 1'b1; tick(1); ce_n = 1'b1; tick(6);
    chk(strobes == s0, "R4 power-up rise ignored", strobes - s0, 0);

    // table of bus writes: R1, R2, R3, R11
    for (int k = 0; k < NV; k++) begin
      s0 = strobes;
      bus_write(VEC[k]);
      chk(strobes - s0 == int'(VEC[k].exp), "R1 R2 R3 strobe count", strobes - s0, VEC[k].exp);
      if (VEC[k].exp) begin
        chk(last_addr == VEC[k].eaddr, "R11 cmd_addr", last_addr, VEC[k].eaddr);
        chk(last_code == VEC[k].ecode, "R11 cmd_code", last_code, VEC[k].ecode);
        chk(last_wdata == VEC[k].ewdata, "R11 cmd_wdata", last_wdata, VEC[k].ewdata);
      end
    end

    // R5: lockout blocks writes and forces read mode
    supply_lock = 1'b1; tick(2);
    chk(read_mode_req == 1'b1, "R5 lockout read-mode", {31'd0, read_mode_req}, 32'd1);
    s0 = strobes;
    bus_write(VEC[0]);
    chk(strobes == s0, "R5 lockout write ignored", strobes - s0, 0);
    supply_lock = 1'b0; tick(3);
    chk(read_mode_req == 1'b0, "R5 lockout released", {31'd0, read_mode_req}, 32'd0);

    // R8: reset pin low during a write and during a read
    wide_sel = 1'b1; ce_n = 1'b0; oe_n = 1'b1; tick(1);
    we_n = 1'b0; tick(2);
    hw_rst_n = 1'b0; tick(3);
    chk(standby == 1'b1 && busy_ignore == 1'b1, "R8 standby flags", {30'd0, standby, busy_ignore}, 32'd3);
    chk(read_allow == 1'b0, "R8 read blocked", {31'd0, read_allow}, 32'd0);
    s0 = strobes;
    we_n = 1'b1; tick(1); oe_n = 1'b0; tick(4);
    chk(dq_oe == 16'h0, "R8 outputs released", {16'd0, dq_oe}, 32'd0);
    ce_n = 1'b1; oe_n = 1'b1; tick(2);
    chk(strobes == s0, "R8 write ignored", strobes - s0, 0);
    hw_rst_n = 1'b1; tick(6);

    // R10: read lane mapping
    addr_pin = 18'h01234; arr_rdata = 16'hBEEF; dq_in = 16'h0000;
    wide_sel = 1'b1; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; tick(4);
    chk(dq_oe == 16'hFFFF, "R10 word dq_oe", {16'd0, dq_oe}, 32'hFFFF);
    chk(dq_out == 16'hBEEF, "R10 word dq_out", {16'd0, dq_out}, 32'hBEEF);
    chk(rd_addr == {18'h01234, 1'b0}, "R10 word rd_addr", {13'd0, rd_addr}, 32'h02468);
    wide_sel = 1'b0; dq_in = 16'h8000; tick(4);
    chk(dq_oe == 16'h00FF, "R10 byte dq_oe", {16'd0, dq_oe}, 32'h00FF);
    chk(dq_out == 16'h00BE, "R10 byte high lane", {16'd0, dq_out}, 32'h00BE);
    chk(rd_addr == {18'h01234, 1'b1}, "R10 byte rd_addr", {13'd0, rd_addr}, 32'h02469);
    dq_in = 16'h0000; tick(4);
    chk(dq_out == 16'h00EF, "R10 byte low lane", {16'd0, dq_out}, 32'h00EF);
    ce_n = 1'b1; oe_n = 1'b1; wide_sel = 1'b1; tick(4);

    // R6: short reset pulse
    r0 = rmr_cyc;
    hw_rst_n = 1'b0; tick(MIN_CYC - 3);
    hw_rst_n = 1'b1; tick(6);
    chk(read_allow == 1'b1, "R6 no recovery after short pulse", {31'd0, read_allow}, 32'd1);
    tick(ABORT_CYC + 20);
    chk(rmr_cyc == r0, "R6 no read-mode request", rmr_cyc - r0, 0);

    // R7 and R9: qualifying pulse released well before the abort time
    r0 = rmr_cyc;
    hw_rst_n = 1'b0; tick(MIN_CYC + 3);
    chk(read_allow == 1'b0, "R9 blocked while low", {31'd0, read_allow}, 32'd0);
    hw_rst_n = 1'b1; tick(4);
    chk(read_allow == 1'b0, "R9 recovery window", {31'd0, read_allow}, 32'd0);
    tick(REC_CYC + 4);
    chk(read_allow == 1'b1, "R9 recovery over", {31'd0, read_allow}, 32'd1);
    tick(ABORT_CYC - 20 - (MIN_CYC + 3) - 8 - REC_CYC);
    chk(rmr_cyc == r0, "R7 not before abort time", rmr_cyc - r0, 0);
    tick(40);
    chk(rmr_cyc - r0 == 1, "R7 one read-mode request", rmr_cyc - r0, 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule